// File: doc/BRIEF.md
# DAC Code Holding and Update Controller

This block is the digital front end of one digital-to-analog converter channel. Software writes a sample through a write strobe, and a two-bit format code says how the bus word is laid out. The block aligns every write into a 12-bit holding register. It then moves the held code into a 12-bit output register, which supplies the code to the converter. The output register cannot be written in any other way.

The move from holding to output happens in one of three ways. In automatic mode the output follows the holding register one clock later. In triggered mode a rising edge on one of eight selectable trigger lines loads the output after a fixed three-clock delay, and a software trigger bit that clears itself does the same. A channel enable gates all loads.

The analog side is outside this block. It produces a voltage equal to the reference times the code divided by 4096.

Top module: `dac_hold_update_ctrl`

## Requirements
- R1: A write with format code 2'b00 (12-bit right-aligned) stores wr_data[11:0] into the holding register at the strobe edge.
- R2: A write with format code 2'b01 (12-bit left-aligned) stores wr_data[15:4] into the holding register.
- R3: A write with format code 2'b10 (8-bit) stores wr_data[7:0] into holding bits [11:4] and clears holding bits [3:0].
- R4: A write with format code 2'b11 is ignored and the holding register keeps its value.
- R5: After reset the holding register, the output code and the software trigger pending bit are all zero.
- R6: With chan_en set and trig_en clear, out_code equals the holding value one clock edge after each edge. The output is only ever loaded from the holding register.
- R7: With chan_en and trig_en set, a rising edge on trig_src[trig_sel] first sampled high at edge E loads out_code from the holding register at edge E+3. A line held high, or an edge on a line that is not selected, loads nothing.
- R8: A trigger detected at edges E+1 to E+3 of a transfer started at E is ignored. It does not cause a second load.
- R9: A sw_trig_set strobe at edge S sets sw_trig_pend. With trig_en set, the pending bit acts as a trigger at S+1, so the output loads at S+4, and the bit clears at that same edge.
- R10: While chan_en is clear, out_code does not change and any transfer under way is abandoned. Writes to the holding register are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; gates every output load |
| trig_en | input | 1 | 1 selects triggered updates, 0 selects automatic updates |
| trig_sel | input | 3 | Selects which trigger line is watched |
| trig_src | input | 8 | Trigger lines, synchronous to clk |
| sw_trig_set | input | 1 | One-clock strobe that sets the software trigger bit |
| wr_stb | input | 1 | Data write strobe |
| wr_fmt | input | 2 | Write format code (see R1 to R4) |
| wr_data | input | 16 | Write bus word |
| hold_code | output | 12 | Holding register contents |
| out_code | output | 12 | Output code sent to the converter |
| sw_trig_pend | output | 1 | Software trigger pending bit |

## Verification
The assertions assume that the trigger lines are already synchronous to clk, because the edge detector samples them directly and has no synchronizer. The stimulus changes every input only on the falling clock edge.

The triggered-path properties assume the holding register is not rewritten while a load is due, since the output takes the value held at the load edge. The bench writes new data inside a window only at the load edge itself, where the old value must still be the one loaded.

The format properties assume wr_fmt is meaningful only while wr_stb is high. The bench holds wr_fmt steady across each strobe.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;

  // Write format codes seen on wr_fmt
  typedef enum logic [1:0] {
    FMT_R12  = 2'b00,
    FMT_L12  = 2'b01,
    FMT_R8   = 2'b10,
    FMT_RSVD = 2'b11
  } wr_fmt_e;

endpackage

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
  import dac_hold_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [1:0]        wr_fmt,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [DATA_W-1:0] hold_code
);

  localparam int PAD_W = DATA_W - BYTE_W;

  // Aligns one bus word into holding-register layout
  function automatic logic [DATA_W-1:0] align_word(input logic [1:0] f,
                                                   input logic [BUS_W-1:0] d);
    case (wr_fmt_e'(f))
      FMT_R12: return d[DATA_W-1:0];
      FMT_L12: return d[BUS_W-1 -: DATA_W];
      FMT_R8:  return {d[BYTE_W-1:0], {PAD_W{1'b0}}};
      default: return '0;
    endcase
  endfunction

  logic wr_take;
  assign wr_take = wr_stb && (wr_fmt != FMT_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_code <= '0;
    else if (wr_take) hold_code <= align_word(wr_fmt, wr_data);
  end

  a_r1_right_align: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_fmt == FMT_R12) |=> hold_code == $past(wr_data[DATA_W-1:0]));
  a_r2_left_align: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_fmt == FMT_L12) |=> hold_code == $past(wr_data[BUS_W-1 -: DATA_W]));
  a_r3_byte_align: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_fmt == FMT_R8) |=>
      (hold_code[DATA_W-1 -: BYTE_W] == $past(wr_data[BYTE_W-1:0]) &&
       hold_code[PAD_W-1:0] == '0));
  a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb || wr_fmt == FMT_RSVD) |=> $stable(hold_code));

endmodule

// File: rtl/dac_trig_detect.sv
module dac_trig_detect #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_src,
  input  logic [SEL_W-1:0]   trig_sel,
  output logic               trig_rise
);

  logic sel_level;
  logic prev_q;

  assign sel_level = trig_src[trig_sel];
  assign trig_rise = sel_level && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_level;
  end

  // R7: a level held high is never seen as two edges in a row
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);

endmodule

// File: rtl/dac_xfer_seq.sv
module dac_xfer_seq #(
  parameter int DATA_W = 12,
  parameter int LAT    = 3,
  parameter int CNT_W  = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              trig_en,
  input  logic              trig_rise,
  input  logic              sw_set,
  input  logic [DATA_W-1:0] hold_code,
  output logic [DATA_W-1:0] out_code,
  output logic              sw_pend
);

  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic [CNT_W-1:0] cnt;
  logic busy, due, trig_evt, trig_accept, auto_load, load_fire;

  assign busy        = (cnt != '0);
  assign due         = (cnt == LAT_C);
  assign trig_evt    = trig_en && (trig_rise || sw_pend);
  assign trig_accept = chan_en && trig_evt && !busy;
  assign auto_load   = chan_en && !trig_en;
  assign load_fire   = auto_load || (chan_en && due);

  // Window counter: 1 at the accept edge, loads when it reaches LAT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!chan_en)    cnt <= '0;
    else if (trig_accept) cnt <= CNT_W'(1);
    else if (due)         cnt <= '0;
    else if (busy)        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_code <= '0;
    else if (load_fire) out_code <= hold_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= 1'b0;
    else        sw_pend <= sw_set || (sw_pend && !load_fire);
  end

  a_r6_auto_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !trig_en) |=> out_code == $past(hold_code));
  a_r7_change_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_code) |-> $past(load_fire));
  a_r8_ignore_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_evt && chan_en) |=> cnt != CNT_W'(1));
  a_r9_sw_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_pend) |-> $past(load_fire));
  a_r10_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> ($stable(out_code) && cnt == '0));

endmodule

// File: rtl/dac_hold_update_ctrl.sv
module dac_hold_update_ctrl #(
  parameter int DATA_W  = 12,
  parameter int BUS_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int NUM_SRC = 8,
  parameter int LAT     = 3,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               trig_en,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [NUM_SRC-1:0] trig_src,
  input  logic               sw_trig_set,
  input  logic               wr_stb,
  input  logic [1:0]         wr_fmt,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [DATA_W-1:0]  hold_code,
  output logic [DATA_W-1:0]  out_code,
  output logic               sw_trig_pend
);

  logic trig_rise;

  dac_hold_reg #(.DATA_W(DATA_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_fmt(wr_fmt),
    .wr_data(wr_data), .hold_code(hold_code)
  );

  dac_trig_detect #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) trig_i (
    .clk(clk), .rst_n(rst_n), .trig_src(trig_src), .trig_sel(trig_sel),
    .trig_rise(trig_rise)
  );

  dac_xfer_seq #(.DATA_W(DATA_W), .LAT(LAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en),
    .trig_rise(trig_rise), .sw_set(sw_trig_set), .hold_code(hold_code),
    .out_code(out_code), .sw_pend(sw_trig_pend)
  );

endmodule

// File: tb/dac_hold_update_ctrl_tb.sv
module dac_hold_update_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, trig_en = 1'b0, sw_trig_set = 1'b0, wr_stb = 1'b0;
  logic [2:0]  trig_sel = '0;
  logic [7:0]  trig_src = '0;
  logic [1:0]  wr_fmt = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] hold_code, out_code;
  logic        sw_trig_pend;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dac_hold_update_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en),
    .trig_sel(trig_sel), .trig_src(trig_src), .sw_trig_set(sw_trig_set),
    .wr_stb(wr_stb), .wr_fmt(wr_fmt), .wr_data(wr_data),
    .hold_code(hold_code), .out_code(out_code), .sw_trig_pend(sw_trig_pend)
  );

  // {format, bus word, expected holding value}
  localparam logic [29:0] VEC [0:7] = '{
    {2'b00, 16'h0ABC, 12'hABC},
    {2'b00, 16'hF123, 12'h123},
    {2'b01, 16'hABCD, 12'hABC},
    {2'b01, 16'h000F, 12'h000},
    {2'b10, 16'h12A5, 12'hA50},
    {2'b10, 16'h00FF, 12'hFF0},
    {2'b00, 16'h0FFF, 12'hFFF},
    {2'b01, 16'hFFF0, 12'hFFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] f, input logic [15:0] d);
    wr_stb = 1'b1; wr_fmt = f; wr_data = d;
    tick(1);
    wr_stb = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R5 hold reset", 16'(hold_code), 16'h000);
    check("R5 out reset", 16'(out_code), 16'h000);
    check("R5 pend reset", 16'(sw_trig_pend), 16'h0);

    // Format table walk in automatic mode (R1 R2 R3 R6)
    chan_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      string tag;
      case (VEC[i][29:28])
        2'b00:   tag = "R1 right12";
        2'b01:   tag = "R2 left12";
        default: tag = "R3 byte";
      endcase
      write(VEC[i][29:28], VEC[i][27:12]);
      check(tag, 16'(hold_code), 16'(VEC[i][11:0]));
      tick(1);
      check("R6 auto follow", 16'(out_code), 16'(VEC[i][11:0]));
    end

    // R4 reserved format
    write(2'b11, 16'h1234);
    check("R4 reserved hold", 16'(hold_code), 16'hFFF);
    tick(1);
    check("R4 reserved out", 16'(out_code), 16'hFFF);

    // R7 triggered path
    trig_en = 1'b1; trig_sel = 3'd5;
    write(2'b00, 16'h0321);
    tick(2);
    check("R7 no load without trigger", 16'(out_code), 16'hFFF);
    trig_src[5] = 1'b1;
    tick(3);
    check("R7 not before third edge", 16'(out_code), 16'hFFF);
    tick(1);
    check("R7 load third edge", 16'(out_code), 16'h321);
    write(2'b00, 16'h0456);
    tick(5);
    check("R7 held level no retrigger", 16'(out_code), 16'h321);
    trig_src[2] = 1'b1;
    tick(5);
    check("R7 unselected line ignored", 16'(out_code), 16'h321);
    trig_src[2] = 1'b0;
    trig_src[5] = 1'b0;
    tick(1);
    trig_src[5] = 1'b1;
    tick(4);
    check("R7 second edge loads", 16'(out_code), 16'h456);

    // R8 trigger inside the window
    trig_src[5] = 1'b0;
    tick(1);
    trig_src[5] = 1'b1;
    write(2'b00, 16'h05A5);
    trig_src[5] = 1'b0;
    tick(1);
    trig_src[5] = 1'b1;
    tick(1);
    write(2'b00, 16'h00C3);
    check("R8 first trigger loads", 16'(out_code), 16'h5A5);
    tick(4);
    check("R8 window trigger ignored", 16'(out_code), 16'h5A5);
    check("R8 hold updated", 16'(hold_code), 16'h0C3);

    // R9 software trigger
    sw_trig_set = 1'b1;
    tick(1);
    sw_trig_set = 1'b0;
    check("R9 pend set", 16'(sw_trig_pend), 16'h1);
    tick(3);
    check("R9 no early load", 16'(out_code), 16'h5A5);
    check("R9 pend held", 16'(sw_trig_pend), 16'h1);
    tick(1);
    check("R9 load fourth edge", 16'(out_code), 16'h0C3);
    check("R9 pend cleared", 16'(sw_trig_pend), 16'h0);

    // R10 channel disabled
    chan_en = 1'b0; trig_en = 1'b0;
    write(2'b00, 16'h09E1);
    tick(3);
    check("R10 out frozen", 16'(out_code), 16'h0C3);
    check("R10 hold accepts write", 16'(hold_code), 16'h9E1);
    chan_en = 1'b1; trig_en = 1'b1;
    trig_src[5] = 1'b0;
    tick(1);
    trig_src[5] = 1'b1;
    tick(1);
    chan_en = 1'b0;
    tick(5);
    chan_en = 1'b1;
    tick(4);
    check("R10 abandoned transfer", 16'(out_code), 16'h0C3);
    trig_en = 1'b0;
    tick(2);
    check("R6 auto after reenable", 16'(out_code), 16'h9E1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule